// File: doc/BRIEF.md
# Edge-Triggered Counter Capture Unit

This block watches an asynchronous event line and takes a snapshot of a free-running counter when a chosen transition occurs on that line. The event line is brought into the clock domain through a synchronizer. The synchronized level is then compared with its value from the previous cycle to find rising and falling transitions. A two-bit selector picks which transitions count. A value of zero disables capture completely.

In single mode, the first qualifying transition loads the first snapshot register and raises a sticky flag. In dual mode, two consecutive transitions load the first and then the second snapshot register. The flag is raised only on the second transition, which makes the pair suitable for measuring the period of a clock fed to the event line. Once the flag is raised, the unit ignores further transitions until it is re-armed. Re-arming happens when a flag that is set is cleared with a write-one strobe, or when the selector leaves the disabled setting. The interrupt output is the flag gated by an enable input.

Top module: `evcap_unit`

## Requirements
- R1: After reset, both snapshot registers read 0, and the flag and the interrupt are low.
- R2: The selector encoding is 0 = no capture, 1 = rising transitions, 2 = falling transitions, 3 = both. With selector 0, no transition changes a snapshot or the flag.
- R3: A snapshot holds the counter value present at the third rising clock edge after the event line changes, when the event line is stable before the first of those edges.
- R4: In single mode (mode input 0), the first qualifying transition loads snapshot 1 and sets the flag.
- R5: In single mode, after the flag is set, further qualifying transitions change neither snapshot until the unit is re-armed.
- R6: In dual mode (mode input 1), the first qualifying transition loads snapshot 1 and leaves the flag low. The second loads snapshot 2 and sets the flag.
- R7: In dual mode, after the second snapshot, further transitions change neither snapshot until the unit is re-armed.
- R8: Snapshot 2 is written only in dual mode.
- R9: A clear strobe while the flag is 1 lowers the flag and re-arms the unit. A clear strobe while the flag is 0 has no effect, so a pending first dual-mode snapshot is kept.
- R10: A change of the selector from 0 to a non-zero value re-arms the unit without lowering the flag.
- R11: The interrupt is high exactly when the flag is high and the interrupt enable is high.
- R12: A pulse on the event line that starts and ends between two rising clock edges is not detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock, also samples the event line |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | CNT_W | Running counter value to snapshot |
| evt_in | input | 1 | Asynchronous event line |
| edge_sel | input | 2 | Transition selector (0 none, 1 rise, 2 fall, 3 both) |
| dual_mode | input | 1 | 0 single snapshot, 1 two snapshots |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag, one cycle |
| cap1 | output | CNT_W | First snapshot register |
| cap2 | output | CNT_W | Second snapshot register |
| cap_flag | output | 1 | Sticky capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the selector, the mode input and the clear strobe are synchronous to the clock. They also assume that a clear strobe does not arrive in the same cycle as a detected transition, because re-arming takes priority and would silently drop that transition. The bench drives every control input on the falling clock edge and changes the event line only on falling edges, except in the deliberate sub-cycle glitch test. It issues each clear strobe while the synchronizer pipeline is idle, so the assumed input discipline always holds.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RISE = 2'd1,
    SEL_FALL = 2'd2,
    SEL_BOTH = 2'd3
  } edge_sel_e;

  // Decide whether a change from prev to cur qualifies under sel.
  function automatic logic edge_hit(input logic [1:0] sel, input logic prev, input logic cur);
    logic up;
    logic down;
    up   = cur & ~prev;
    down = prev & ~cur;
    case (edge_sel_e'(sel))
      SEL_RISE: edge_hit = up;
      SEL_FALL: edge_hit = down;
      SEL_BOTH: edge_hit = up | down;
      default:  edge_hit = 1'b0;
    endcase
  endfunction

  // Re-arm on selector leaving the disabled setting.
  function automatic logic sel_arms(input logic [1:0] old_sel, input logic [1:0] new_sel);
    sel_arms = (edge_sel_e'(old_sel) == SEL_NONE) && (edge_sel_e'(new_sel) != SEL_NONE);
  endfunction

endpackage

// File: rtl/evcap_sync.sv
module evcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_out = chain_q[LAST];
endmodule

// File: rtl/evcap_edge.sv
module evcap_edge
  import evcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [1:0] sel,
  output logic       hit
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign hit = edge_hit(sel, prev_q, lvl);

  // R2
  edge_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (lvl != prev_q) && (sel != 2'd0));
endmodule

// File: rtl/evcap_ctrl.sv
module evcap_ctrl
  import evcap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [1:0]       edge_sel,
  input  logic             dual_mode,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap1,
  output logic [CNT_W-1:0] cap2,
  output logic             flag
);
  logic       locked_q;
  logic       got1_q;
  logic [1:0] sel_q;

  logic clr_ok;
  logic sel_rearm;
  logic rearm;
  logic take;

  assign clr_ok    = flag_clr & flag;
  assign sel_rearm = sel_arms(sel_q, edge_sel);
  assign rearm     = clr_ok | sel_rearm;
  assign take      = hit & ~locked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap1     <= '0;
      cap2     <= '0;
      flag     <= 1'b0;
      locked_q <= 1'b0;
      got1_q   <= 1'b0;
      sel_q    <= SEL_NONE;
    end else begin
      sel_q <= edge_sel;
      if (rearm) begin
        locked_q <= 1'b0;
        got1_q   <= 1'b0;
        if (clr_ok) flag <= 1'b0;
      end else if (take) begin
        if (dual_mode && !got1_q) begin
          cap1   <= cnt_val;
          got1_q <= 1'b1;
        end else if (dual_mode) begin
          cap2     <= cnt_val;
          flag     <= 1'b1;
          locked_q <= 1'b1;
          got1_q   <= 1'b0;
        end else begin
          cap1     <= cnt_val;
          flag     <= 1'b1;
          locked_q <= 1'b1;
        end
      end
    end
  end

  // R4
  flag_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));

  // R9
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(flag_clr));

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(cap1) && $stable(cap2));

  // R8
  single_no_cap2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap2) |-> $past(dual_mode));
endmodule

// File: rtl/evcap_unit.sv
module evcap_unit #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             evt_in,
  input  logic [1:0]       edge_sel,
  input  logic             dual_mode,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap1,
  output logic [CNT_W-1:0] cap2,
  output logic             cap_flag,
  output logic             cap_irq
);
  logic evt_sync;
  logic evt_hit;

  evcap_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (evt_in),
    .q_out (evt_sync)
  );

  evcap_edge edge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (evt_sync),
    .sel   (edge_sel),
    .hit   (evt_hit)
  );

  evcap_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (evt_hit),
    .cnt_val   (cnt_val),
    .edge_sel  (edge_sel),
    .dual_mode (dual_mode),
    .flag_clr  (flag_clr),
    .cap1      (cap1),
    .cap2      (cap2),
    .flag      (cap_flag)
  );

  assign cap_irq = cap_flag & irq_en;

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> (irq_en && cap_flag));
endmodule

// File: tb/evcap_unit_tb.sv
`timescale 1ns/100ps
module evcap_unit_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] cnt_val = '0;
  logic         evt_in;
  logic [1:0]   edge_sel;
  logic         dual_mode;
  logic         irq_en;
  logic         flag_clr;
  logic [W-1:0] cap1;
  logic [W-1:0] cap2;
  logic         cap_flag;
  logic         cap_irq;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic [W-1:0] v;
  logic [W-1:0] keep1;
  logic [W-1:0] keep2;

  always #2 clk = ~clk;
  always @(negedge clk) cnt_val <= cnt_val + 1;

  evcap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .evt_in(evt_in),
    .edge_sel(edge_sel), .dual_mode(dual_mode), .irq_en(irq_en),
    .flag_clr(flag_clr), .cap1(cap1), .cap2(cap2),
    .cap_flag(cap_flag), .cap_irq(cap_irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Change the event line on a falling edge, note the counter, then wait
  // until three rising edges have passed and sample on the next falling edge.
  task automatic drive_evt(input logic val);
    @(negedge clk);
    evt_in = val;
    #1 v = cnt_val;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_sel(input logic [1:0] s);
    @(negedge clk);
    edge_sel = s;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; evt_in = 1'b0; edge_sel = 2'd0;
    dual_mode = 1'b0; irq_en = 1'b0; flag_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cap1", cap1, '0);
    check("R1 cap2", cap2, '0);
    check("R1 flag", {31'd0, cap_flag}, 0);
    check("R1 irq", {31'd0, cap_irq}, 0);
  endtask

  task automatic t_none();
    drive_evt(1'b1);
    drive_evt(1'b0);
    check("R2 none cap1", cap1, '0);
    check("R2 none flag", {31'd0, cap_flag}, 0);
  endtask

  task automatic t_single();
    set_sel(2'd1);
    irq_en = 1'b1;
    drive_evt(1'b1);
    check("R3 R4 cap1", cap1, v + 2);
    check("R4 flag", {31'd0, cap_flag}, 1);
    check("R11 irq on", {31'd0, cap_irq}, 1);
    keep1 = cap1;
    drive_evt(1'b0);
    drive_evt(1'b1);
    check("R5 locked cap1", cap1, keep1);
    check("R8 cap2 untouched", cap2, '0);
    @(negedge clk);
    irq_en = 1'b0;
    #1 check("R11 irq masked", {31'd0, cap_irq}, 0);
    irq_en = 1'b1;
  endtask

  task automatic t_clear();
    pulse_clear();
    check("R9 flag cleared", {31'd0, cap_flag}, 0);
    drive_evt(1'b0);
    check("R2 rise ignores fall", {31'd0, cap_flag}, 0);
    drive_evt(1'b1);
    check("R9 rearmed cap1", cap1, v + 2);
    check("R9 flag again", {31'd0, cap_flag}, 1);
  endtask

  task automatic t_sel_rearm();
    set_sel(2'd0);
    set_sel(2'd1);
    drive_evt(1'b0);
    drive_evt(1'b1);
    check("R10 cap1 after sel rearm", cap1, v + 2);
    check("R10 flag kept", {31'd0, cap_flag}, 1);
  endtask

  task automatic t_fall_both();
    pulse_clear();
    set_sel(2'd2);
    drive_evt(1'b0);
    check("R2 falling cap1", cap1, v + 2);
    pulse_clear();
    set_sel(2'd3);
    drive_evt(1'b1);
    check("R2 both rise cap1", cap1, v + 2);
    pulse_clear();
    drive_evt(1'b0);
    check("R2 both fall cap1", cap1, v + 2);
  endtask

  task automatic t_dual();
    pulse_clear();
    set_sel(2'd1);
    dual_mode = 1'b1;
    drive_evt(1'b1);
    keep1 = v + 2;
    check("R6 first cap1", cap1, keep1);
    check("R6 flag low", {31'd0, cap_flag}, 0);
    check("R6 irq low", {31'd0, cap_irq}, 0);
    drive_evt(1'b0);
    pulse_clear();
    drive_evt(1'b1);
    check("R9 R6 second cap2", cap2, v + 2);
    check("R6 cap1 kept", cap1, keep1);
    check("R6 flag set", {31'd0, cap_flag}, 1);
    check("R11 irq dual", {31'd0, cap_irq}, 1);
    keep2 = cap2;
    drive_evt(1'b0);
    drive_evt(1'b1);
    check("R7 cap1 locked", cap1, keep1);
    check("R7 cap2 locked", cap2, keep2);
  endtask

  task automatic t_glitch();
    pulse_clear();
    dual_mode = 1'b0;
    set_sel(2'd3);
    keep1 = cap1;
    @(posedge clk);
    #0.5 evt_in = 1'b0;
    #1 evt_in = 1'b1;
    repeat (5) @(negedge clk);
    check("R12 glitch flag", {31'd0, cap_flag}, 0);
    check("R12 glitch cap1", cap1, keep1);
  endtask

  initial begin
    t_reset();
    t_none();
    t_single();
    t_clear();
    t_sel_rearm();
    t_fall_both();
    t_dual();
    t_glitch();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule